// File: doc/BRIEF.md
# Time-Sliced Shared RAM Arbiter

This block lets three clients share one external asynchronous byte-wide RAM from a single master clock of about 21.48 MHz. It makes its own pixel-rate enable (one master cycle in four) and processor-rate enable (one master cycle in twelve). It then cuts time into slots of one pixel period each. Every slot carries at most one single-byte access. Slot ownership does not depend on who is asking. A fixed six-slot rotation gives the graphics client every even slot, the processor client one slot per processor period, and the loader client the one odd slot that is left over.

Each client holds a request, a write flag, an address and write data. If its request is up in the first cycle of one of its own slots, the block drives the RAM for that slot. A read returns the byte on a shared response bus, along with a one-cycle valid pulse for that client in the last cycle of the slot. A client that is not requesting in its slot loses that slot, and the RAM stays idle for it. A synchronous reset restarts the rotation at slot 0, in a cycle where both enables are high.

Top module: `mem_slot_arbiter`

## Requirements
- R1: `pix_en` is high in exactly one master cycle out of every four. It is high in the first cycle after reset is released (cycle 0) and in every cycle whose index is a multiple of 4.
- R2: `cpu_en` is high only in cycles that are a multiple of 12 counted from cycle 0. It is therefore always high together with `pix_en`, at the start of slot 0 or slot 3 of the rotation.
- R3: Slot k spans cycles 4k to 4k+3. `ram_addr` changes only at the clock edge that ends the first cycle of a slot.
- R4: Owner by slot index (k mod 6): slots 0, 2 and 4 belong to graphics, slots 1 and 3 to the processor, and slot 5 to the loader. Only the owner's address reaches `ram_addr`, and a request made in a slot the client does not own is not served.
- R5: For a granted read, `ram_ce_n` and `ram_oe_n` are low in cycles 1 and 2 of the slot. The RAM data is sampled at the edge that ends cycle 2, which is two full cycles after the address appears.
- R6: A read raises the owner's valid output (`gfx_rvalid`, `cpu_rvalid` or `ldr_rvalid`) for cycle 3 of the slot only, and `rsp_data` then holds the byte read. No more than one valid is high at a time, and a write raises none.
- R7: If the owner is not requesting in cycle 0 of its slot, the slot stays idle: `ram_ce_n` stays high, `ram_addr` keeps its old value and no valid is raised.
- R8: For a granted write, `ram_we_n` is low in cycles 1 and 2 and high in cycle 3. `ram_dq_oe` is high in cycles 1 to 3 with the write data on `ram_wdata`, and low from cycle 0 of the next slot. `ram_oe_n` stays high throughout.
- R9: While `rst` is high and in cycle 0 after its release, every RAM strobe is inactive, `ram_dq_oe` and all valids are low, and the rotation begins at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_en | output | 1 | Pixel-rate clock enable |
| cpu_en | output | 1 | Processor-rate clock enable |
| gfx_req | input | 1 | Graphics access request |
| gfx_we | input | 1 | Graphics write flag |
| gfx_addr | input | ADDR_W | Graphics byte address |
| gfx_wdata | input | DATA_W | Graphics write byte |
| gfx_rvalid | output | 1 | Graphics read data valid |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | Processor write flag |
| cpu_addr | input | ADDR_W | Processor byte address |
| cpu_wdata | input | DATA_W | Processor write byte |
| cpu_rvalid | output | 1 | Processor read data valid |
| ldr_req | input | 1 | Loader access request |
| ldr_we | input | 1 | Loader write flag |
| ldr_addr | input | ADDR_W | Loader byte address |
| ldr_wdata | input | DATA_W | Loader write byte |
| ldr_rvalid | output | 1 | Loader read data valid |
| rsp_data | output | DATA_W | Last byte read, shared by all clients |
| ram_addr | output | ADDR_W | RAM address |
| ram_wdata | output | DATA_W | RAM write data |
| ram_dq_oe | output | 1 | Drive enable for the RAM data bus |
| ram_rdata | input | DATA_W | RAM read data |
| ram_ce_n | output | 1 | RAM chip enable, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |

## Verification
The design holds three small counters: the phase inside a slot, the processor divider, and the slot index. If any of them slips, the error shows at the ports within one slot of four cycles. The RAM address then carries the wrong client's address in cycle 1, or the valid pulse lands on the wrong client or in the wrong cycle. A processor divider that is off moves `cpu_en` away from the 12-cycle grid by the next pixel enable. The bench's RAM model returns data only one cycle after the address settles, so a shortened read wait returns stale data in `rsp_data` during that same slot. Strobe or data-enable windows that run too long or too short are seen in the cycle where the edge is misplaced.

// File: rtl/slot_arb_pkg.sv
package slot_arb_pkg;

   localparam int NCLIENT = 3;

   typedef enum logic [1:0] {
      CL_GFX  = 2'd0,
      CL_CPU  = 2'd1,
      CL_LDR  = 2'd2,
      CL_NONE = 2'd3
   } client_e;

   // Even slots feed graphics; in each processor window the first odd slot
   // goes to the processor; any other odd slot goes to the loader.
   function automatic client_e owner_of(int unsigned slot, int unsigned cpu_div);
      int unsigned win_base;
      int unsigned first_odd;
      if ((slot % 2) == 0) return CL_GFX;
      win_base  = (slot / cpu_div) * cpu_div;
      first_odd = ((win_base % 2) == 1) ? win_base : win_base + 1;
      if (slot == first_odd) return CL_CPU;
      return CL_LDR;
   endfunction

endpackage

// File: rtl/slot_arb_enables.sv
module slot_arb_enables #(
   parameter int PIX_DIV = 4,
   parameter int CPU_DIV = 3,
   parameter int PH_W    = $clog2(PIX_DIV)
) (
   input  logic            clk,
   input  logic            rst,
   output logic [PH_W-1:0] phase,
   output logic            pix_en,
   output logic            cpu_en
);

   localparam int CD_W = $clog2(CPU_DIV);
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(PIX_DIV - 1);
   localparam logic [CD_W-1:0] CD_LAST = CD_W'(CPU_DIV - 1);

   if (PIX_DIV < 3) begin : g_bad_pix_div
      $error("slot_arb_enables: PIX_DIV must be at least 3");
   end
   if (CPU_DIV < 2) begin : g_bad_cpu_div
      $error("slot_arb_enables: CPU_DIV must be at least 2");
   end

   logic [PH_W-1:0] ph_q;
   logic [CD_W-1:0] cd_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         ph_q <= '0;
         cd_q <= '0;
      end else if (ph_q == PH_LAST) begin
         ph_q <= '0;
         cd_q <= (cd_q == CD_LAST) ? '0 : cd_q + 1'b1;
      end else begin
         ph_q <= ph_q + 1'b1;
      end
   end

   assign phase  = ph_q;
   assign pix_en = (ph_q == '0);
   assign cpu_en = pix_en && (cd_q == '0);

   // R1
   pix_gap_chk: assert property (@(posedge clk) disable iff (rst)
      pix_en |=> !pix_en);

   // R2
   cpu_in_pix_chk: assert property (@(posedge clk) disable iff (rst)
      cpu_en |-> pix_en);

endmodule

// File: rtl/slot_arb_sched.sv
module slot_arb_sched
   import slot_arb_pkg::*;
#(
   parameter int PIX_DIV = 4,
   parameter int CPU_DIV = 3,
   parameter int PH_W    = $clog2(PIX_DIV),
   parameter int SLOTS   = 2 * CPU_DIV,
   parameter int SL_W    = $clog2(SLOTS)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [PH_W-1:0] phase,
   output logic [SL_W-1:0] slot,
   output client_e         owner
);

   localparam logic [PH_W-1:0] PH_LAST   = PH_W'(PIX_DIV - 1);
   localparam logic [SL_W-1:0] SLOT_LAST = SL_W'(SLOTS - 1);

   if (SLOTS != 2 * CPU_DIV) begin : g_bad_slots
      $error("slot_arb_sched: SLOTS must equal twice CPU_DIV");
   end

   client_e own_tab [SLOTS];

   for (genvar s = 0; s < SLOTS; s++) begin : g_own
      assign own_tab[s] = owner_of(s, CPU_DIV);
   end

   logic [SL_W-1:0] slot_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         slot_q <= '0;
      end else if (phase == PH_LAST) begin
         slot_q <= (slot_q == SLOT_LAST) ? '0 : slot_q + 1'b1;
      end
   end

   assign slot  = slot_q;
   assign owner = own_tab[slot_q];

   // R3
   slot_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (phase != '0) |-> $stable(slot_q));

endmodule

// File: rtl/slot_arb_ram_seq.sv
module slot_arb_ram_seq
   import slot_arb_pkg::*;
#(
   parameter int ADDR_W  = 24,
   parameter int DATA_W  = 8,
   parameter int PIX_DIV = 4,
   parameter int RD_WAIT = 2,
   parameter int PH_W    = $clog2(PIX_DIV)
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic [PH_W-1:0]                phase,
   input  client_e                        owner,
   input  logic [NCLIENT-1:0]             cl_req,
   input  logic [NCLIENT-1:0]             cl_we,
   input  logic [NCLIENT-1:0][ADDR_W-1:0] cl_addr,
   input  logic [NCLIENT-1:0][DATA_W-1:0] cl_wdata,
   output logic [NCLIENT-1:0]             rvalid,
   output logic [DATA_W-1:0]              rsp_data,
   output logic [ADDR_W-1:0]              ram_addr,
   output logic [DATA_W-1:0]              ram_wdata,
   output logic                           ram_dq_oe,
   input  logic [DATA_W-1:0]              ram_rdata,
   output logic                           ram_ce_n,
   output logic                           ram_oe_n,
   output logic                           ram_we_n
);

   localparam logic [PH_W-1:0] PH_SAMPLE = PH_W'(RD_WAIT);
   localparam logic [PH_W-1:0] PH_VALID  = PH_W'(RD_WAIT + 1);
   localparam logic [PH_W-1:0] PH_LAST   = PH_W'(PIX_DIV - 1);

   if (RD_WAIT < 1 || RD_WAIT + 2 > PIX_DIV) begin : g_bad_wait
      $error("slot_arb_ram_seq: RD_WAIT must lie in 1 .. PIX_DIV-2");
   end

   logic [NCLIENT-1:0] hit;
   logic [NCLIENT-1:0] act_cl;
   logic               act_wr;
   logic [ADDR_W-1:0]  sel_addr;
   logic [DATA_W-1:0]  sel_wdata;
   logic               sel_we;
   logic               grant;

   for (genvar c = 0; c < NCLIENT; c++) begin : g_hit
      assign hit[c] = cl_req[c] && (owner == client_e'(c));
   end

   always_comb begin
      sel_addr  = '0;
      sel_wdata = '0;
      sel_we    = 1'b0;
      for (int c = 0; c < NCLIENT; c++) begin
         if (hit[c]) begin
            sel_addr  = sel_addr  | cl_addr[c];
            sel_wdata = sel_wdata | cl_wdata[c];
            sel_we    = sel_we    | cl_we[c];
         end
      end
   end

   assign grant = (phase == '0) && (|hit);

   always_ff @(posedge clk) begin
      if (rst) begin
         ram_addr  <= '0;
         ram_wdata <= '0;
         ram_dq_oe <= 1'b0;
         ram_ce_n  <= 1'b1;
         ram_oe_n  <= 1'b1;
         ram_we_n  <= 1'b1;
         act_cl    <= '0;
         act_wr    <= 1'b0;
         rvalid    <= '0;
         rsp_data  <= '0;
      end else begin
         rvalid <= '0;
         if (phase == '0) begin
            if (grant) begin
               ram_addr  <= sel_addr;
               ram_wdata <= sel_wdata;
               ram_ce_n  <= 1'b0;
               ram_oe_n  <= sel_we;
               ram_we_n  <= !sel_we;
               ram_dq_oe <= sel_we;
               act_wr    <= sel_we;
               act_cl    <= hit;
            end else begin
               act_cl    <= '0;
               act_wr    <= 1'b0;
            end
         end
         if (phase == PH_SAMPLE) begin
            ram_ce_n <= 1'b1;
            ram_oe_n <= 1'b1;
            ram_we_n <= 1'b1;
            if ((|act_cl) && !act_wr) begin
               rsp_data <= ram_rdata;
               rvalid   <= act_cl;
            end
         end
         if (phase == PH_LAST) begin
            ram_dq_oe <= 1'b0;
         end
      end
   end

   // R3
   addr_move_chk: assert property (@(posedge clk) disable iff (rst)
      !$stable(ram_addr) |-> ($past(phase) == '0));

   // R5
   ce_window_chk: assert property (@(posedge clk) disable iff (rst)
      !ram_ce_n |-> ((phase != '0) && (phase <= PH_SAMPLE)));

   if (RD_WAIT >= 2) begin : g_ce_len
      // R5
      ce_len_chk: assert property (@(posedge clk) disable iff (rst)
         $fell(ram_ce_n) |=> !ram_ce_n);
   end

   // R6
   one_valid_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(rvalid));

   // R6
   valid_phase_chk: assert property (@(posedge clk) disable iff (rst)
      (|rvalid) |-> (phase == PH_VALID));

   // R8
   we_drive_chk: assert property (@(posedge clk) disable iff (rst)
      !ram_we_n |-> (ram_dq_oe && !ram_ce_n && ram_oe_n));

   // R8
   we_release_chk: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_LAST) |-> ram_we_n);

endmodule

// File: rtl/mem_slot_arbiter.sv
module mem_slot_arbiter
   import slot_arb_pkg::*;
#(
   parameter int ADDR_W  = 24,
   parameter int DATA_W  = 8,
   parameter int PIX_DIV = 4,
   parameter int CPU_DIV = 3,
   parameter int RD_WAIT = 2
) (
   input  logic              clk,
   input  logic              rst,
   output logic              pix_en,
   output logic              cpu_en,
   input  logic              gfx_req,
   input  logic              gfx_we,
   input  logic [ADDR_W-1:0] gfx_addr,
   input  logic [DATA_W-1:0] gfx_wdata,
   output logic              gfx_rvalid,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_rvalid,
   input  logic              ldr_req,
   input  logic              ldr_we,
   input  logic [ADDR_W-1:0] ldr_addr,
   input  logic [DATA_W-1:0] ldr_wdata,
   output logic              ldr_rvalid,
   output logic [DATA_W-1:0] rsp_data,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [DATA_W-1:0] ram_wdata,
   output logic              ram_dq_oe,
   input  logic [DATA_W-1:0] ram_rdata,
   output logic              ram_ce_n,
   output logic              ram_oe_n,
   output logic              ram_we_n
);

   localparam int PH_W  = $clog2(PIX_DIV);
   localparam int SLOTS = 2 * CPU_DIV;
   localparam int SL_W  = $clog2(SLOTS);

   logic [PH_W-1:0]                phase;
   logic [SL_W-1:0]                slot;
   client_e                        owner;
   logic [NCLIENT-1:0]             cl_req;
   logic [NCLIENT-1:0]             cl_we;
   logic [NCLIENT-1:0][ADDR_W-1:0] cl_addr;
   logic [NCLIENT-1:0][DATA_W-1:0] cl_wdata;
   logic [NCLIENT-1:0]             rvalid;

   assign cl_req   = {ldr_req, cpu_req, gfx_req};
   assign cl_we    = {ldr_we, cpu_we, gfx_we};
   assign cl_addr  = {ldr_addr, cpu_addr, gfx_addr};
   assign cl_wdata = {ldr_wdata, cpu_wdata, gfx_wdata};

   assign gfx_rvalid = rvalid[CL_GFX];
   assign cpu_rvalid = rvalid[CL_CPU];
   assign ldr_rvalid = rvalid[CL_LDR];

   slot_arb_enables #(
      .PIX_DIV (PIX_DIV),
      .CPU_DIV (CPU_DIV),
      .PH_W    (PH_W)
   ) u_enables (
      .clk    (clk),
      .rst    (rst),
      .phase  (phase),
      .pix_en (pix_en),
      .cpu_en (cpu_en)
   );

   slot_arb_sched #(
      .PIX_DIV (PIX_DIV),
      .CPU_DIV (CPU_DIV),
      .PH_W    (PH_W),
      .SLOTS   (SLOTS),
      .SL_W    (SL_W)
   ) u_sched (
      .clk   (clk),
      .rst   (rst),
      .phase (phase),
      .slot  (slot),
      .owner (owner)
   );

   slot_arb_ram_seq #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .PIX_DIV (PIX_DIV),
      .RD_WAIT (RD_WAIT),
      .PH_W    (PH_W)
   ) u_ram_seq (
      .clk       (clk),
      .rst       (rst),
      .phase     (phase),
      .owner     (owner),
      .cl_req    (cl_req),
      .cl_we     (cl_we),
      .cl_addr   (cl_addr),
      .cl_wdata  (cl_wdata),
      .rvalid    (rvalid),
      .rsp_data  (rsp_data),
      .ram_addr  (ram_addr),
      .ram_wdata (ram_wdata),
      .ram_dq_oe (ram_dq_oe),
      .ram_rdata (ram_rdata),
      .ram_ce_n  (ram_ce_n),
      .ram_oe_n  (ram_oe_n),
      .ram_we_n  (ram_we_n)
   );

   // R2
   cpu_slot_chk: assert property (@(posedge clk) disable iff (rst)
      cpu_en |-> ((int'(slot) % CPU_DIV) == 0));

   // R4
   pix_slot_start_chk: assert property (@(posedge clk) disable iff (rst)
      (pix_en && (slot == '0)) |=> (slot == '0));

endmodule

// File: tb/mem_slot_arbiter_bench.sv
module mem_slot_arbiter_bench;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int AW = 24;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          pix_en, cpu_en;
   logic          gfx_req = 0, gfx_we = 0, cpu_req = 0, cpu_we = 0, ldr_req = 0, ldr_we = 0;
   logic [AW-1:0] gfx_addr = '0, cpu_addr = '0, ldr_addr = '0;
   logic [DW-1:0] gfx_wdata = '0, cpu_wdata = '0, ldr_wdata = '0;
   logic          gfx_rvalid, cpu_rvalid, ldr_rvalid;
   logic [DW-1:0] rsp_data;
   logic [AW-1:0] ram_addr;
   logic [DW-1:0] ram_wdata, ram_rdata;
   logic          ram_dq_oe, ram_ce_n, ram_oe_n, ram_we_n;

   int n_vec = 0;
   int n_bad = 0;
   int cyc   = 0;

   always #2.5 clk = ~clk;

   mem_slot_arbiter u_mem_slot_arbiter (
      .clk(clk), .rst(rst), .pix_en(pix_en), .cpu_en(cpu_en),
      .gfx_req(gfx_req), .gfx_we(gfx_we), .gfx_addr(gfx_addr), .gfx_wdata(gfx_wdata), .gfx_rvalid(gfx_rvalid),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rvalid(cpu_rvalid),
      .ldr_req(ldr_req), .ldr_we(ldr_we), .ldr_addr(ldr_addr), .ldr_wdata(ldr_wdata), .ldr_rvalid(ldr_rvalid),
      .rsp_data(rsp_data), .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_dq_oe(ram_dq_oe),
      .ram_rdata(ram_rdata), .ram_ce_n(ram_ce_n), .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n)
   );

   // RAM model: data follows the address after one cycle, so a read
   // sampled too early returns the previous location.
   logic [7:0] mem [256];
   logic [7:0] ram_late;
   initial for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
   always @(posedge clk) begin
      ram_late <= mem[ram_addr[7:0]];
      if (!ram_ce_n && !ram_we_n && ram_dq_oe) mem[ram_addr[7:0]] <= ram_wdata;
   end
   assign ram_rdata = (!ram_ce_n && !ram_oe_n) ? ram_late : 8'hEE;

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   task automatic step();
      @(posedge clk);
      cyc++;
      @(negedge clk);
   endtask

   task automatic do_reset(input int n);
      rst = 1'b1;
      repeat (n) @(negedge clk);
      rst = 1'b0;
      cyc = 0;
   endtask

   task automatic idle_all();
      gfx_req = 0; gfx_we = 0; cpu_req = 0; cpu_we = 0; ldr_req = 0; ldr_we = 0;
   endtask

   // Slot owner from R4: 0 graphics, 1 processor, 2 loader.
   function automatic int own(input int c);
      int s;
      s = (c / 4) % 6;
      if (s % 2 == 0) return 0;
      if (s == 5) return 2;
      return 1;
   endfunction

   function automatic logic [AW-1:0] addr_of(input int o);
      return (o == 0) ? gfx_addr : (o == 1) ? cpu_addr : ldr_addr;
   endfunction

   task automatic test_reset();
      idle_all();
      do_reset(3);
      chk("R9", "pix_en", 32'(pix_en), 1);
      chk("R9", "cpu_en", 32'(cpu_en), 1);
      chk("R9", "ce_n", 32'(ram_ce_n), 1);
      chk("R9", "we_n", 32'(ram_we_n), 1);
      chk("R9", "oe_n", 32'(ram_oe_n), 1);
      chk("R9", "dq_oe", 32'(ram_dq_oe), 0);
      chk("R9", "valids", 32'({ldr_rvalid, cpu_rvalid, gfx_rvalid}), 0);
   endtask

   task automatic test_enables();
      idle_all();
      do_reset(2);
      for (int k = 0; k < 48; k++) begin
         chk("R1", "pix_en", 32'(pix_en), 32'(cyc % 4 == 0));
         chk("R2", "cpu_en", 32'(cpu_en), 32'(cyc % 12 == 0));
         step();
      end
   endtask

   task automatic test_schedule();
      int o, p;
      idle_all();
      gfx_addr = 24'hA00011; cpu_addr = 24'hB00022; ldr_addr = 24'hC00033;
      gfx_req = 1; cpu_req = 1; ldr_req = 1;
      do_reset(2);
      for (int k = 0; k < 48; k++) begin
         o = own(cyc);
         p = cyc % 4;
         if (p == 1) begin
            chk("R4", "ram_addr owner", 32'(ram_addr), 32'(addr_of(o)));
            chk("R5", "ce_n in c1", 32'(ram_ce_n), 0);
            chk("R5", "oe_n in c1", 32'(ram_oe_n), 0);
         end else if (p == 2) begin
            chk("R5", "ce_n in c2", 32'(ram_ce_n), 0);
         end else if (p == 3) begin
            chk("R5", "ce_n in c3", 32'(ram_ce_n), 1);
            chk("R6", "valid owner", 32'({ldr_rvalid, cpu_rvalid, gfx_rvalid}), 32'(1 << o));
            chk("R6", "rsp_data", 32'(rsp_data), 32'(addr_of(o)) & 32'hFF ^ 32'h5A);
         end else if (cyc > 0) begin
            chk("R6", "valid low c0", 32'({ldr_rvalid, cpu_rvalid, gfx_rvalid}), 0);
         end
         step();
      end
      idle_all();
   endtask

   task automatic test_forfeit();
      int o, p;
      idle_all();
      gfx_addr = 24'h000077; ldr_addr = 24'h000066; cpu_addr = 24'h000044;
      cpu_req = 1;
      do_reset(2);
      for (int k = 0; k < 24; k++) begin
         o = own(cyc);
         p = cyc % 4;
         if (p == 1) begin
            chk("R7", "ce_n forfeited/served", 32'(ram_ce_n), 32'(o != 1));
            if (cyc > 8) chk("R7", "addr held", 32'(ram_addr), 32'h44);
         end else if (p == 3) begin
            chk("R7", "valid only cpu", 32'({ldr_rvalid, cpu_rvalid, gfx_rvalid}), (o == 1) ? 2 : 0);
         end
         step();
      end
      idle_all();
   endtask

   task automatic test_write();
      idle_all();
      cpu_req = 1; cpu_we = 1; cpu_addr = 24'h000080; cpu_wdata = 8'hC3;
      do_reset(2);
      step();
      chk("R4", "gfx slot idle", 32'(ram_ce_n), 1);
      while (cyc < 5) step();
      cpu_req = 0; cpu_we = 0;
      chk("R8", "we_n c1", 32'(ram_we_n), 0);
      chk("R8", "oe_n c1", 32'(ram_oe_n), 1);
      chk("R8", "dq_oe c1", 32'(ram_dq_oe), 1);
      chk("R8", "wdata", 32'(ram_wdata), 32'hC3);
      chk("R8", "addr", 32'(ram_addr), 32'h80);
      step();
      chk("R8", "we_n c2", 32'(ram_we_n), 0);
      step();
      chk("R8", "we_n c3", 32'(ram_we_n), 1);
      chk("R8", "dq_oe c3", 32'(ram_dq_oe), 1);
      chk("R6", "no valid on write", 32'(cpu_rvalid), 0);
      step();
      chk("R8", "dq_oe next slot", 32'(ram_dq_oe), 0);
      gfx_req = 1; gfx_addr = 24'h000080;
      step();
      gfx_req = 0;
      step();
      step();
      chk("R6", "gfx valid readback", 32'(gfx_rvalid), 1);
      chk("R8", "written byte", 32'(rsp_data), 32'hC3);
      idle_all();
   endtask

   task automatic test_mid_reset();
      idle_all();
      gfx_req = 1; gfx_addr = 24'h000031;
      do_reset(2);
      repeat (7) step();
      gfx_addr = 24'h000055;
      do_reset(2);
      chk("R9", "pix_en after reset", 32'(pix_en), 1);
      chk("R9", "cpu_en after reset", 32'(cpu_en), 1);
      chk("R9", "ce_n after reset", 32'(ram_ce_n), 1);
      step();
      chk("R9", "slot 0 served", 32'(ram_ce_n), 0);
      chk("R9", "slot 0 addr", 32'(ram_addr), 32'h55);
      step();
      step();
      chk("R9", "slot 0 valid", 32'(gfx_rvalid), 1);
      chk("R9", "slot 0 data", 32'(rsp_data), 32'h55 ^ 32'h5A);
      idle_all();
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   initial begin
      @(negedge clk);
      test_reset();
      test_enables();
      test_schedule();
      test_forfeit();
      test_write();
      test_mid_reset();
      summary();
      $finish;
   end

   initial begin
      #(200000 * 5);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

endmodule